// File: doc/BRIEF.md
# Predicated Merging Vector OR Unit

This block takes two vectors and a byte-granular predicate and produces a vector in which every active element is the bitwise OR of the two sources. Every inactive element is a copy of the first source. The first source is also the destination, so the caller writes the result back over it. The element width is chosen per operation by a 2-bit size code: 8, 16, 32 or 64 bits.

The predicate carries one bit for each byte of the vector. For an element that is wider than a byte, only the bit for the element's lowest byte decides whether the element is active. The other bits in its byte group have no effect. When the predicate leaves no element active under the selected size, the second source is forced to zero, so the result equals the first source.

Each accepted operation produces exactly one registered result on the following clock. The vector length is a parameter and must be a multiple of 128 bits.

Top module: `vor_merge_unit`

## Requirements
- R1: The size code selects the element width. Code 0 gives 8 bits, code 1 gives 16 bits, code 2 gives 32 bits and code 3 gives 64 bits. Element e covers vector bits e*W up to e*W+W-1, where W is the element width.
- R2: For an active element, the result element equals the first-source element ORed bitwise with the second-source element.
- R3: For an inactive element, the result element equals the first-source element unchanged.
- R4: Element e is active when predicate bit e*W/8 is 1. Predicate bit i governs byte i, which is bits 8i to 8i+7. Predicate bits at the other bytes of the element have no effect.
- R5: When no element is active under the selected size, the result equals the first source. This covers an all-zero predicate and a predicate with only non-leading bits set.
- R6: A result and its valid flag appear on the clock edge after an input with `in_valid` high. `out_valid` is low one cycle after any cycle with `in_valid` low, and back-to-back inputs give back-to-back results.
- R7: A synchronous active-high `rst` drives `out_valid` low on the next edge, and it overrides an input presented in the same cycle.
- R8: `result` keeps its value across cycles in which no input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operation is present this cycle |
| size_code | input | 2 | Element width select (0:8, 1:16, 2:32, 3:64 bits) |
| pred | input | VEC_BITS/8 | Predicate, one bit per vector byte |
| src_a | input | VEC_BITS | First source and destination vector |
| src_b | input | VEC_BITS | Second source vector |
| out_valid | output | 1 | Result is valid |
| result | output | VEC_BITS | Merged result vector |

## Verification
The bench uses predicates whose only set bits sit off the leading byte of every wider element. A design that read any bit of the byte group, or ORed the whole group, would mark those elements active and change them, where the correct result is the first source. A single leading predicate bit with a zero first source and an all-ones second source exposes the element width directly: a mis-decoded size code shows up as a wrong run of ones. All-zero and all-ones predicates at every size separate a design that zeroes inactive elements from one that merges them. A reset raised while an input is present, and idle cycles between operations, catch a result that leaks through the reset or drifts while nothing is accepted.

// File: rtl/vor_pkg.sv
package vor_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'd0,
      ESZ_HALF  = 2'd1,
      ESZ_WORD  = 2'd2,
      ESZ_DWORD = 2'd3
   } esz_e;

   localparam int NUM_SIZES = 4;
   localparam int LANE_BITS = 8;
   localparam int VEC_QUANTUM = 128;

   function automatic int unsigned esz_bytes(input int unsigned code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/vor_active_decode.sv
module vor_active_decode
   import vor_pkg::*;
#(
   parameter int PRED_BITS = 16
) (
   input  esz_e                 size,
   input  logic [PRED_BITS-1:0] pred,
   output logic [PRED_BITS-1:0] byte_en,
   output logic                 any_active
);

   logic [NUM_SIZES-1:0] any_per_size;

   // each byte lane takes the predicate bit of its element's leading byte
   for (genvar gi = 0; gi < PRED_BITS; gi++) begin : g_byte
      logic [NUM_SIZES-1:0] lead_bit;
      for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_sz
         localparam int GRP  = int'(esz_bytes(gs));
         localparam int LEAD = (gi / GRP) * GRP;
         assign lead_bit[gs] = pred[LEAD];
      end
      assign byte_en[gi] = lead_bit[2'(size)];
   end

   // per size: is any leading bit set
   for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_any
      localparam int GRP = int'(esz_bytes(gs));
      logic [PRED_BITS-1:0] lead_only;
      for (genvar gi = 0; gi < PRED_BITS; gi++) begin : g_bit
         if ((gi % GRP) == 0) begin : g_lead
            assign lead_only[gi] = pred[gi];
         end else begin : g_skip
            assign lead_only[gi] = 1'b0;
         end
      end
      assign any_per_size[gs] = |lead_only;
   end

   assign any_active = any_per_size[2'(size)];

endmodule

// File: rtl/vor_lane_merge.sv
module vor_lane_merge #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] lane_a,
   input  logic [WIDTH-1:0] lane_b,
   input  logic             lane_en,
   input  logic             kill_b,
   output logic [WIDTH-1:0] lane_out
);

   logic [WIDTH-1:0] b_eff;

   always_comb begin
      b_eff    = kill_b ? '0 : lane_b;
      lane_out = lane_en ? (lane_a | b_eff) : lane_a;
   end

endmodule

// File: rtl/vor_out_stage.sv
module vor_out_stage #(
   parameter int WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic             q_valid,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
      end else begin
         q_valid <= load;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/vor_merge_unit.sv
module vor_merge_unit
   import vor_pkg::*;
#(
   parameter int VEC_BITS = 128
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [1:0]            size_code,
   input  logic [VEC_BITS/8-1:0] pred,
   input  logic [VEC_BITS-1:0]   src_a,
   input  logic [VEC_BITS-1:0]   src_b,
   output logic                  out_valid,
   output logic [VEC_BITS-1:0]   result
);

   localparam int PRED_BITS = VEC_BITS / LANE_BITS;

   if ((VEC_BITS % VEC_QUANTUM) != 0 || VEC_BITS < VEC_QUANTUM) begin : g_bad_len
      $error("vor_merge_unit: VEC_BITS must be a nonzero multiple of 128");
   end

   esz_e                 size_sel;
   logic [PRED_BITS-1:0] byte_en;
   logic                 any_active;
   logic [VEC_BITS-1:0]  merged;

   assign size_sel = esz_e'(size_code);

   vor_active_decode #(
      .PRED_BITS(PRED_BITS)
   ) i_decode (
      .size      (size_sel),
      .pred      (pred),
      .byte_en   (byte_en),
      .any_active(any_active)
   );

   for (genvar gl = 0; gl < PRED_BITS; gl++) begin : g_lane
      vor_lane_merge #(
         .WIDTH(LANE_BITS)
      ) i_lane (
         .lane_a  (src_a[gl*LANE_BITS +: LANE_BITS]),
         .lane_b  (src_b[gl*LANE_BITS +: LANE_BITS]),
         .lane_en (byte_en[gl]),
         .kill_b  (~any_active),
         .lane_out(merged[gl*LANE_BITS +: LANE_BITS])
      );
   end

   vor_out_stage #(
      .WIDTH(VEC_BITS)
   ) i_out (
      .clk    (clk),
      .rst    (rst),
      .load   (in_valid),
      .d      (merged),
      .q_valid(out_valid),
      .q      (result)
   );

endmodule

// File: rtl/vor_merge_chk.sv
module vor_merge_chk #(
   parameter int VEC_BITS = 128
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  in_valid,
   input logic [1:0]            size_code,
   input logic [VEC_BITS/8-1:0] pred,
   input logic [VEC_BITS-1:0]   src_a,
   input logic [VEC_BITS-1:0]   src_b,
   input logic                  out_valid,
   input logic [VEC_BITS-1:0]   result
);

   logic rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q) begin
         assert_reset_clears_R7: assert (!out_valid)
            else $error("out_valid high after reset");
      end
   end

   assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   assert_keeps_a_R3: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ((result & $past(src_a)) == $past(src_a)));

   assert_within_or_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ((result & ~($past(src_a) | $past(src_b))) == '0));

   assert_no_active_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pred == '0) |=> (result == $past(src_a)));

   assert_byte_full_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size_code == 2'd0 && (&pred)) |=>
         (result == ($past(src_a) | $past(src_b))));

endmodule

bind vor_merge_unit vor_merge_chk #(.VEC_BITS(VEC_BITS)) i_chk (.*);

// File: tb/test_vor_merge_unit.sv
module test_vor_merge_unit;

   localparam int W  = 128;
   localparam int PW = W / 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [1:0]    size_code;
   logic [PW-1:0] pred;
   logic [W-1:0]  src_a;
   logic [W-1:0]  src_b;
   logic          out_valid;
   logic [W-1:0]  result;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   vor_merge_unit #(.VEC_BITS(W)) i_vor_merge_unit (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .size_code(size_code),
      .pred     (pred),
      .src_a    (src_a),
      .src_b    (src_b),
      .out_valid(out_valid),
      .result   (result)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [PW-1:0] p, input int sz);
      logic [W-1:0] r;
      int esz;
      r   = a;
      esz = 8 << sz;
      for (int e = 0; e < W / esz; e++) begin
         if (p[e * esz / 8]) begin
            for (int k = e * esz; k < (e + 1) * esz; k++) r[k] = a[k] | b[k];
         end
      end
      return r;
   endfunction

   function automatic logic [W-1:0] rnd_vec();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: out_valid actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: result actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, check at the next negedge (one register)
   task automatic send(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [PW-1:0] p, input int sz);
      logic [W-1:0] exp;
      exp       = model(a, b, p, sz);
      in_valid  = 1'b1;
      src_a     = a;
      src_b     = b;
      pred      = p;
      size_code = 2'(sz);
      @(negedge clk);
      check_bit("R6", out_valid, 1'b1);
      check_vec(req, result, exp);
   endtask

   task automatic idle(input string req, input logic [W-1:0] last);
      in_valid = 1'b0;
      src_a    = rnd_vec();
      src_b    = rnd_vec();
      pred     = 16'(rnd_vec());
      @(negedge clk);
      check_bit("R6", out_valid, 1'b0);
      check_vec(req, result, last);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      rst = 1'b1; in_valid = 1'b0; size_code = 2'd0;
      pred = '0; src_a = '0; src_b = '0;
      repeat (3) @(negedge clk);
      check_bit("R7", out_valid, 1'b0);
      rst = 1'b0;

      // R1: single leading bit, zero a, ones b -> run of ones as wide as the element
      for (int sz = 0; sz < 4; sz++) begin
         send("R1", '0, '1, 16'h0001, sz);
      end

      // R2 all active, R5 none active, per size; back-to-back covers R6
      for (int sz = 0; sz < 4; sz++) begin
         send("R2", rnd_vec(), rnd_vec(), '1, sz);
         send("R5", rnd_vec(), rnd_vec(), '0, sz);
      end

      // R4: only non-leading bits set -> nothing active
      send("R4", rnd_vec(), rnd_vec(), 16'hAAAA, 1);
      send("R4", rnd_vec(), rnd_vec(), 16'hEEEE, 2);
      send("R4", rnd_vec(), rnd_vec(), 16'hFEFE, 3);
      // R4: leading bit only of upper dword element
      send("R4", '0, '1, 16'h0100, 3);

      // R3/R4: random predicates at every size
      for (int n = 0; n < 40; n++) begin
         send("R3", rnd_vec(), rnd_vec(), 16'($urandom), n % 4);
      end

      // R8: idle cycles keep the last result
      a = rnd_vec(); b = rnd_vec();
      send("R2", a, b, '1, 0);
      idle("R8", a | b);
      idle("R8", a | b);

      // R7: reset wins over a simultaneous input
      rst = 1'b1; in_valid = 1'b1; src_a = rnd_vec(); src_b = rnd_vec(); pred = '1;
      @(negedge clk);
      check_bit("R7", out_valid, 1'b0);
      rst = 1'b0;
      send("R2", 128'h0F, 128'hF0, 16'h0001, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule